// File: doc/BRIEF.md
# PWM Timer Counter Synchronization Array

This block holds the period timers of a set of PWM submodules. Each submodule has a 16-bit up-counter that restarts from its own start value (INIT) when a restart event arrives. The submodule picks its restart source from four options: its own modulus match, a shared master reload pulse, the modulus match of submodule 0 (the master sync), or an external sync input.

A force input, enabled per submodule, restarts the counter whatever source is selected. With the local option a submodule runs free on its own modulus, so the modulus alone sets its period. With one of the other options the submodule's timer is locked to submodule 0 or to the external source, and its modulus compare is free for other uses.

Each submodule's modulus-match output is brought to the ports. Submodule 0's match is also fanned out as the master sync.

Top module: `pwm_sync_array`

## Requirements
- R1: When no restart event occurs, each counter increases by exactly one on every clock.
- R2: `local_sync[k]` is 1 exactly while counter k equals its modulus `mod_val` slice, and 0 otherwise.
- R3: The 2-bit select field of submodule k is encoded as follows: 0 = own modulus match, 1 = master reload, 2 = master sync, 3 = external sync. With a select other than 0, a counter passes through its modulus value and keeps counting, with no restart.
- R4: A restart event is a rising edge of the selected source: the source is 0 in one cycle and 1 in the next. The counter loads its INIT slice on the clock edge that ends the cycle in which the source is first 1. A source that stays high causes only one load.
- R5: The master sync is `local_sync[0]`. A submodule with select 2 restarts on the same clock edge as submodule 0 running with select 0.
- R6: A synchronous active-high reset loads every counter with its INIT slice and clears all edge history.
- R7: A counter wraps from 0xFFFF to 0x0000 when no restart event occurs.
- R8: A rising edge on `force_out` restarts every submodule whose `force_en` bit is 1, whatever its select. Submodules whose `force_en` bit is 0 ignore it.
- R9: If a restart event occurs in the same cycle as a modulus match, the counter loads INIT instead of incrementing.
- R10: A `master_reload` pulse restarts only the submodules with select 1. All other submodules ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Submodule clock |
| rst | input | 1 | Synchronous active-high reset |
| init_val | input | NUM_SUB*CNT_W | Start value per submodule; slice k is [k*CNT_W +: CNT_W] |
| mod_val | input | NUM_SUB*CNT_W | Modulus per submodule |
| init_sel | input | NUM_SUB*2 | Restart-source select per submodule (encoding in R3) |
| force_en | input | NUM_SUB | Per-submodule enable for the force restart |
| ext_sync | input | 1 | External sync source, shared |
| force_out | input | 1 | Force restart request, shared |
| master_reload | input | 1 | Register-reload pulse from submodule 0, shared |
| count | output | NUM_SUB*CNT_W | Counter values |
| local_sync | output | NUM_SUB | Modulus match per submodule |

## Verification
The assertions check on every cycle that a counter with no restart event steps by one, wrapping at the top. They also check that each detected source edge, each local modulus edge and each enabled force edge is followed by a load of INIT. Only the bench's scenarios can show the system-level behaviour, because it depends on several submodules and on exact timing. This covers the lock of a master-sync follower to submodule 0, the selectivity of master reload and force across submodules, and the single load caused by a held source. It also covers the priority of a restart over a modulus match and the free pass through the modulus in non-local modes.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    typedef enum logic [1:0] {
        SRC_LOCAL   = 2'd0,
        SRC_MRELOAD = 2'd1,
        SRC_MSYNC   = 2'd2,
        SRC_EXT     = 2'd3
    } init_src_e;

    typedef struct packed {
        logic own_match;
        logic mreload;
        logic msync;
        logic ext;
    } sync_srcs_t;

    function automatic logic pick_source(init_src_e sel, sync_srcs_t s);
        case (sel)
            SRC_LOCAL:   return s.own_match;
            SRC_MRELOAD: return s.mreload;
            SRC_MSYNC:   return s.msync;
            default:     return s.ext;
        endcase
    endfunction

endpackage

// File: rtl/pwm_rise_det.sv
module pwm_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/pwm_sub_counter.sv
module pwm_sub_counter
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [1:0]       init_sel,
    input  logic             force_en,
    input  logic             master_reload,
    input  logic             master_sync,
    input  logic             ext_sync,
    input  logic             force_out,
    output logic [CNT_W-1:0] count,
    output logic             local_sync
);
    init_src_e  sel_e;
    sync_srcs_t srcs;
    logic       sel_level;
    logic       src_rise;
    logic       force_rise;
    logic       init_evt;
    logic [CNT_W-1:0] cnt_q;

    assign sel_e      = init_src_e'(init_sel);
    assign local_sync = (cnt_q == mod_val);
    assign srcs       = '{own_match: local_sync, mreload: master_reload,
                          msync: master_sync, ext: ext_sync};
    assign sel_level  = pick_source(sel_e, srcs);

    pwm_rise_det u_src_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sel_level),
        .rise  (src_rise)
    );

    pwm_rise_det u_force_edge (
        .clk   (clk),
        .rst   (rst),
        .level (force_out),
        .rise  (force_rise)
    );

    assign init_evt = src_rise | (force_en & force_rise);

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= init_val;
        else if (init_evt) cnt_q <= init_val;
        else               cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count = cnt_q;

    // R1 / R7: plain step with natural wrap when nothing restarts the counter
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        !init_evt |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))
        else $error("p_step_r1");

    // R4: a detected source edge loads INIT
    p_src_load_r4: assert property (@(posedge clk) disable iff (rst)
        src_rise |=> cnt_q == $past(init_val))
        else $error("p_src_load_r4");

    // R3: in local mode a new modulus match restarts the counter
    p_local_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_e == SRC_LOCAL && $stable(init_sel) && $rose(local_sync))
        |=> cnt_q == $past(init_val))
        else $error("p_local_restart_r3");

    // R8: an enabled force edge loads INIT whatever the select
    p_force_r8: assert property (@(posedge clk) disable iff (rst)
        (force_en && $rose(force_out)) |=> cnt_q == $past(init_val))
        else $error("p_force_r8");
endmodule

// File: rtl/pwm_sync_array.sv
module pwm_sync_array
    import pwm_sync_pkg::*;
#(
    parameter int NUM_SUB = 4,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SUB*CNT_W-1:0] init_val,
    input  logic [NUM_SUB*CNT_W-1:0] mod_val,
    input  logic [NUM_SUB*2-1:0]     init_sel,
    input  logic [NUM_SUB-1:0]       force_en,
    input  logic                     ext_sync,
    input  logic                     force_out,
    input  logic                     master_reload,
    output logic [NUM_SUB*CNT_W-1:0] count,
    output logic [NUM_SUB-1:0]       local_sync
);
    localparam int SEL_W = 2;

    logic sync0;

    for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
        if (k == 0) begin : g_master
            pwm_sub_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk           (clk),
                .rst           (rst),
                .init_val      (init_val[k*CNT_W +: CNT_W]),
                .mod_val       (mod_val[k*CNT_W +: CNT_W]),
                .init_sel      (init_sel[k*SEL_W +: SEL_W]),
                .force_en      (force_en[k]),
                .master_reload (master_reload),
                .master_sync   (sync0),
                .ext_sync      (ext_sync),
                .force_out     (force_out),
                .count         (count[k*CNT_W +: CNT_W]),
                .local_sync    (sync0)
            );
            assign local_sync[k] = sync0;
        end else begin : g_follow
            pwm_sub_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk           (clk),
                .rst           (rst),
                .init_val      (init_val[k*CNT_W +: CNT_W]),
                .mod_val       (mod_val[k*CNT_W +: CNT_W]),
                .init_sel      (init_sel[k*SEL_W +: SEL_W]),
                .force_en      (force_en[k]),
                .master_reload (master_reload),
                .master_sync   (sync0),
                .ext_sync      (ext_sync),
                .force_out     (force_out),
                .count         (count[k*CNT_W +: CNT_W]),
                .local_sync    (local_sync[k])
            );
        end
    end
endmodule

// File: tb/pwm_sync_array_tb.sv
module pwm_sync_array_tb;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*W-1:0] init_val;
    logic [N*W-1:0] mod_val;
    logic [N*2-1:0] init_sel;
    logic [N-1:0]   force_en;
    logic           ext_sync = 1'b0;
    logic           force_out = 1'b0;
    logic           master_reload = 1'b0;
    logic [N*W-1:0] count;
    logic [N-1:0]   local_sync;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_sync_array #(.NUM_SUB(N), .CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .init_val(init_val), .mod_val(mod_val),
        .init_sel(init_sel), .force_en(force_en), .ext_sync(ext_sync),
        .force_out(force_out), .master_reload(master_reload),
        .count(count), .local_sync(local_sync)
    );

    function automatic logic [W-1:0] cnt(int k);
        return count[k*W +: W];
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: reset loads INIT
    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        for (int k = 0; k < N; k++) chk("R6 reset count", 32'(cnt(k)), 32'(init_val[k*W +: W]));
        rst = 1'b0;
    endtask

    // R1, R2, R3, R5: local period on sub0, sub1 follows master sync
    task automatic t_local_and_msync();
        logic [W-1:0] e0, e1, e2;
        e0 = 16'd10; e1 = 16'd100; e2 = 16'd200;
        for (int i = 0; i < 14; i++) begin
            chk("R2 local_sync0", 32'(local_sync[0]), 32'(e0 == 16'd14));
            tick();
            e1 = (e0 == 16'd14) ? 16'd100 : e1 + 16'd1;
            e0 = (e0 == 16'd14) ? 16'd10  : e0 + 16'd1;
            e2 = e2 + 16'd1;
            chk("R3 local period sub0", 32'(cnt(0)), 32'(e0));
            chk("R5 master sync follower", 32'(cnt(1)), 32'(e1));
            chk("R1 free count sub2", 32'(cnt(2)), 32'(e2));
        end
    endtask

    // R4: external sync edge, held level loads once
    task automatic t_ext();
        ext_sync = 1'b1;
        tick();
        chk("R4 ext edge load", 32'(cnt(2)), 32'd200);
        tick();
        chk("R4 held level no reload", 32'(cnt(2)), 32'd201);
        ext_sync = 1'b0;
        tick();
        chk("R4 after release", 32'(cnt(2)), 32'd202);
    endtask

    // R9, R3, R7: priority over match, pass through modulus, wrap
    task automatic t_prio_wrap();
        tick(); tick(); tick();
        chk("R2 match sub2", 32'(local_sync[2]), 32'd1);
        ext_sync = 1'b1;
        tick();
        chk("R9 restart beats match", 32'(cnt(2)), 32'd200);
        ext_sync = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk("R3 modulus reached non-local", 32'(cnt(2)), 32'd205);
        tick();
        chk("R3 pass through modulus", 32'(cnt(2)), 32'd206);
        init_val[2*W +: W] = 16'hFFFE;
        ext_sync = 1'b1;
        tick();
        chk("R7 load near top", 32'(cnt(2)), 32'hFFFE);
        ext_sync = 1'b0;
        tick();
        chk("R7 top", 32'(cnt(2)), 32'hFFFF);
        tick();
        chk("R7 wrap to zero", 32'(cnt(2)), 32'h0000);
    endtask

    // R10: master reload only for select 1
    task automatic t_mreload();
        logic [W-1:0] c2;
        c2 = cnt(2);
        master_reload = 1'b1;
        tick();
        chk("R10 reload sub3", 32'(cnt(3)), 32'd300);
        chk("R10 ext-mode sub2 ignores", 32'(cnt(2)), 32'(W'(c2 + 16'd1)));
        master_reload = 1'b0;
        tick();
        chk("R10 after pulse", 32'(cnt(3)), 32'd301);
    endtask

    // R8: force restart gated per submodule
    task automatic t_force();
        logic [W-1:0] c2;
        tick(); tick();
        c2 = cnt(2);
        force_out = 1'b1;
        tick();
        chk("R8 enabled force load", 32'(cnt(3)), 32'd300);
        chk("R8 disabled force ignored", 32'(cnt(2)), 32'(W'(c2 + 16'd1)));
        tick();
        chk("R8 held force no reload", 32'(cnt(3)), 32'd301);
        force_out = 1'b0;
    endtask

    initial begin
        init_val = {16'd300, 16'd200, 16'd100, 16'd10};
        mod_val  = {16'd0,   16'd205, 16'd50,  16'd14};
        init_sel = {2'd1, 2'd3, 2'd2, 2'd0};
        force_en = 4'b1000;
        t_reset();
        t_local_and_msync();
        t_ext();
        t_prio_wrap();
        t_mreload();
        t_force();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule